// File: doc/BRIEF.md
# Uncore performance event counter unit

A memory-mapped bank of 64-bit event counters that watches the traffic of a coherency agent with two ports. Each counter is steered by an 8-bit event code to one of a handful of event sources: the clock itself, or the write-data and read-data beat pulses of port 0 and port 1. A counter advances by one on every clock edge at which its selected source is high, provided both a global run bit and the counter's own enable bit are set.

Software programs and reads the unit through a simple single-cycle register port. A counter that wraps from all ones to zero latches a sticky overflow flag. The flags are combined with an active-high mask into a single level interrupt. Software clears flags by writing ones to a separate clear register. A configuration bit is brought out as a level that tells the surrounding power-management logic to hold off while counting. A read-only identifier register lets software tell revisions apart.

Top module: `perf_counter_unit`

## Requirements
- R1: After reset every register reads zero except the mask at 0x1C70, which reads 0xFF. `irq` and `pm_hold` are low.
- R2: Counter n sits at 0x1D00 + 8*n and is written and read as one 64-bit word on `bus_wdata`/`bus_rdata`.
- R3: The event code of counter n is byte (n mod 4) of the select word at 0x1C80 (n < 4) or 0x1C84 (n >= 4), i.e. bits [8*(n mod 4)+7 : 8*(n mod 4)]. Code 0x00 selects every cycle, 0x61 selects `beat_p1_wr`, 0x62 selects `beat_p1_rd`, 0xE1 selects `beat_p0_wr` and 0xE2 selects `beat_p0_rd`. Every other code never counts. The select words read back as written.
- R4: Counter n adds one at a clock edge only when bit 0 of 0x1C00, bit n of 0x1C04 and its selected event are all high at that edge. It never adds more than one per edge.
- R5: A counter that wraps from all ones to zero sets status bit n of 0x1C78 at that same edge. Writes to 0x1C78 are ignored.
- R6: `irq` is high exactly when some status bit n is set while mask bit n is 0. A 1 in the mask blocks that counter.
- R7: Writing to 0x1C7C clears the status bits whose write-data bit is 1 and leaves the others unchanged. A wrap at the same edge keeps its bit set.
- R8: A software write to a counter at the same edge as an increment loads the written value, and the increment is lost.
- R9: Bit 9 of the word at 0x0534 is stored and drives `pm_hold`. The other bits of that word read as zero.
- R10: 0x1CF0 reads the `VERSION_ID` parameter, and writes to it are ignored.
- R11: Read data appears on `bus_rdata` after the clock edge that samples the read and holds until the next read. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address of the register |
| bus_wdata | input | 64 | Write data (32-bit registers use bits 31:0) |
| bus_rdata | output | 64 | Registered read data |
| beat_p0_wr | input | 1 | Port 0 write-data beat pulse |
| beat_p0_rd | input | 1 | Port 0 read-data beat pulse |
| beat_p1_wr | input | 1 | Port 1 write-data beat pulse |
| beat_p1_rd | input | 1 | Port 1 read-data beat pulse |
| irq | output | 1 | Level overflow interrupt |
| pm_hold | output | 1 | Request to suppress power management |

## Verification
- **Register writes:** a write, a count step and a wrap all take effect at the clock edge that samples them, and the status flag is set at that same edge.
- **Interrupt:** `irq` follows the stored status and mask with no added register. It is therefore valid right after that edge.
- **Reads:** `bus_rdata` is loaded at the edge that samples the read.
- **Cycle counting:** the bench drives every input on the falling edge and samples on the next falling edge, so each result is checked exactly one rising edge after its stimulus. Expected cycle counts include the edge on which the run bit is cleared, because that write lands at the same edge as the last increment.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  // Register offsets (software-visible, fixed)
  localparam int unsigned OFF_RUN     = 32'h1C00;
  localparam int unsigned OFF_ENA     = 32'h1C04;
  localparam int unsigned OFF_MASK    = 32'h1C70;
  localparam int unsigned OFF_STAT    = 32'h1C78;
  localparam int unsigned OFF_CLR     = 32'h1C7C;
  localparam int unsigned OFF_SEL     = 32'h1C80;
  localparam int unsigned OFF_VER     = 32'h1CF0;
  localparam int unsigned OFF_CNT     = 32'h1D00;
  localparam int unsigned OFF_CFG     = 32'h0534;
  localparam int unsigned CNT_STRIDE  = 8;
  localparam int unsigned SEL_STRIDE  = 4;
  localparam int unsigned CODE_W      = 8;
  localparam int unsigned LANES       = 4;
  localparam int unsigned PM_BIT      = 9;

  // Beat vector positions
  localparam int unsigned BEAT_P0_WR = 0;
  localparam int unsigned BEAT_P0_RD = 1;
  localparam int unsigned BEAT_P1_WR = 2;
  localparam int unsigned BEAT_P1_RD = 3;
  localparam int unsigned NUM_BEATS  = 4;

  // Event codes
  localparam logic [CODE_W-1:0] EV_CYCLES = 8'h00;
  localparam logic [CODE_W-1:0] EV_P1_WR  = 8'h61;
  localparam logic [CODE_W-1:0] EV_P1_RD  = 8'h62;
  localparam logic [CODE_W-1:0] EV_P0_WR  = 8'hE1;
  localparam logic [CODE_W-1:0] EV_P0_RD  = 8'hE2;
endpackage

// File: rtl/pcu_event_sel.sv
module pcu_event_sel
  import pcu_pkg::*;
(
  input  logic [CODE_W-1:0]    code,
  input  logic [NUM_BEATS-1:0] beats,
  output logic                 hit
);
  always_comb begin
    case (code)
      EV_CYCLES: hit = 1'b1;
      EV_P1_WR:  hit = beats[BEAT_P1_WR];
      EV_P1_RD:  hit = beats[BEAT_P1_RD];
      EV_P0_WR:  hit = beats[BEAT_P0_WR];
      EV_P0_RD:  hit = beats[BEAT_P0_RD];
      default:   hit = 1'b0;  // unassigned codes never count
    endcase
  end
endmodule

// File: rtl/pcu_counter.sv
module pcu_counter #(
  parameter int unsigned CTR_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CTR_W-1:0] wdata,
  input  logic             inc,
  output logic [CTR_W-1:0] q,
  output logic             wrap
);
  // Software write wins over an increment in the same cycle
  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (wr)  q <= wdata;
    else if (inc) q <= q + 1'b1;
  end

  assign wrap = inc & ~wr & (&q);
endmodule

// File: rtl/perf_counter_unit.sv
module perf_counter_unit
  import pcu_pkg::*;
#(
  parameter int unsigned NUM_CTR    = 8,
  parameter int unsigned CTR_W      = 64,
  parameter int unsigned ADDR_W     = 16,
  parameter logic [31:0] VERSION_ID = 32'h0003_0200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CTR_W-1:0]  bus_wdata,
  output logic [CTR_W-1:0]  bus_rdata,
  input  logic              beat_p0_wr,
  input  logic              beat_p0_rd,
  input  logic              beat_p1_wr,
  input  logic              beat_p1_rd,
  output logic              irq,
  output logic              pm_hold
);
  localparam int unsigned NUM_SEL = (NUM_CTR + LANES - 1) / LANES;

  function automatic logic at(input logic [ADDR_W-1:0] a, input int unsigned off);
    return a == ADDR_W'(off);
  endfunction

  logic                           wr_acc, rd_acc, clr_wr, cfg_wr;
  logic                           glob_en;
  logic [NUM_CTR-1:0]             cnt_en_q, mask_q, stat_q;
  logic [NUM_CTR-1:0]             ev_hit, inc, ctr_wr, wrap_vec, clr_bits;
  logic [NUM_CTR-1:0][CODE_W-1:0] codes_q;
  logic [NUM_CTR-1:0][CTR_W-1:0]  cnt_q;
  logic [NUM_BEATS-1:0]           beats;
  logic [CTR_W-1:0]               rd_mux;

  assign wr_acc = bus_sel & bus_wr;
  assign rd_acc = bus_sel & ~bus_wr;
  assign clr_wr = wr_acc & at(bus_addr, OFF_CLR);
  assign cfg_wr = wr_acc & at(bus_addr, OFF_CFG);

  always_comb begin
    beats             = '0;
    beats[BEAT_P0_WR] = beat_p0_wr;
    beats[BEAT_P0_RD] = beat_p0_rd;
    beats[BEAT_P1_WR] = beat_p1_wr;
    beats[BEAT_P1_RD] = beat_p1_rd;
  end

  // Counter slices
  for (genvar n = 0; n < NUM_CTR; n++) begin : g_ctr
    pcu_event_sel u_sel (
      .code  (codes_q[n]),
      .beats (beats),
      .hit   (ev_hit[n])
    );
    assign inc[n]    = glob_en & cnt_en_q[n] & ev_hit[n];
    assign ctr_wr[n] = wr_acc & at(bus_addr, OFF_CNT + CNT_STRIDE * n);
    pcu_counter #(.CTR_W(CTR_W)) u_ctr (
      .clk   (clk),
      .rst   (rst),
      .wr    (ctr_wr[n]),
      .wdata (bus_wdata),
      .inc   (inc[n]),
      .q     (cnt_q[n]),
      .wrap  (wrap_vec[n])
    );
  end

  // Control registers
  always_ff @(posedge clk) begin
    if (rst) begin
      glob_en  <= 1'b0;
      cnt_en_q <= '0;
      mask_q   <= '1;
      pm_hold  <= 1'b0;
      codes_q  <= '0;
    end else if (wr_acc) begin
      if (at(bus_addr, OFF_RUN))  glob_en  <= bus_wdata[0];
      if (at(bus_addr, OFF_ENA))  cnt_en_q <= bus_wdata[NUM_CTR-1:0];
      if (at(bus_addr, OFF_MASK)) mask_q   <= bus_wdata[NUM_CTR-1:0];
      if (cfg_wr)                 pm_hold  <= bus_wdata[PM_BIT];
      for (int k = 0; k < NUM_SEL; k++) begin
        if (at(bus_addr, OFF_SEL + SEL_STRIDE * k)) begin
          for (int l = 0; l < LANES; l++) begin
            if (k * LANES + l < NUM_CTR)
              codes_q[k*LANES+l] <= bus_wdata[CODE_W*l +: CODE_W];
          end
        end
      end
    end
  end

  // Sticky overflow status: a wrap beats a clear at the same edge
  assign clr_bits = clr_wr ? bus_wdata[NUM_CTR-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= (stat_q & ~clr_bits) | wrap_vec;
  end

  assign irq = |(stat_q & ~mask_q);

  // Read path
  always_comb begin
    rd_mux = '0;
    if (at(bus_addr, OFF_RUN))  rd_mux[0]           = glob_en;
    if (at(bus_addr, OFF_ENA))  rd_mux[NUM_CTR-1:0] = cnt_en_q;
    if (at(bus_addr, OFF_MASK)) rd_mux[NUM_CTR-1:0] = mask_q;
    if (at(bus_addr, OFF_STAT)) rd_mux[NUM_CTR-1:0] = stat_q;
    if (at(bus_addr, OFF_VER))  rd_mux[31:0]        = VERSION_ID;
    if (at(bus_addr, OFF_CFG))  rd_mux[PM_BIT]      = pm_hold;
    for (int k = 0; k < NUM_SEL; k++) begin
      if (at(bus_addr, OFF_SEL + SEL_STRIDE * k)) begin
        for (int l = 0; l < LANES; l++) begin
          if (k * LANES + l < NUM_CTR)
            rd_mux[CODE_W*l +: CODE_W] = codes_q[k*LANES+l];
        end
      end
    end
    for (int n = 0; n < NUM_CTR; n++) begin
      if (at(bus_addr, OFF_CNT + CNT_STRIDE * n)) rd_mux = cnt_q[n];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (rd_acc) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
  parameter int unsigned NUM_CTR = 8,
  parameter int unsigned CTR_W   = 64
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          glob_en,
  input logic [NUM_CTR-1:0]            cnt_en_q,
  input logic [NUM_CTR-1:0]            ctr_wr,
  input logic [NUM_CTR-1:0][CTR_W-1:0] cnt_q,
  input logic [NUM_CTR-1:0]            stat_q,
  input logic [NUM_CTR-1:0]            mask_q,
  input logic                          irq,
  input logic [CTR_W-1:0]              bus_wdata,
  input logic                          clr_wr,
  input logic                          cfg_wr,
  input logic                          pm_hold
);
  for (genvar n = 0; n < NUM_CTR; n++) begin : g_chk
    assert_hold_when_off_R4: assert property (@(posedge clk) disable iff (rst)
      ((!glob_en || !cnt_en_q[n]) && !ctr_wr[n]) |=> cnt_q[n] == $past(cnt_q[n]));

    assert_single_step_R4: assert property (@(posedge clk) disable iff (rst)
      !ctr_wr[n] |=> (cnt_q[n] == $past(cnt_q[n]) || cnt_q[n] == $past(cnt_q[n]) + 1'b1));

    assert_wrap_flags_R5: assert property (@(posedge clk) disable iff (rst)
      (!ctr_wr[n] && (&cnt_q[n])) ##1 (cnt_q[n] == '0) |-> stat_q[n]);

    assert_clear_only_by_write_R7: assert property (@(posedge clk) disable iff (rst)
      $fell(stat_q[n]) |-> $past(clr_wr && bus_wdata[n]));

    assert_write_wins_R8: assert property (@(posedge clk) disable iff (rst)
      ctr_wr[n] |=> cnt_q[n] == $past(bus_wdata));
  end

  assert_no_irq_without_status_R6: assert property (@(posedge clk) disable iff (rst)
    (stat_q == '0) |-> !irq);

  assert_no_irq_all_masked_R6: assert property (@(posedge clk) disable iff (rst)
    (&mask_q) |-> !irq);

  assert_pm_moves_on_write_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(pm_hold) |-> $past(cfg_wr));
endmodule

bind perf_counter_unit pcu_checker #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W)) u_pcu_checker (
  .clk       (clk),
  .rst       (rst),
  .glob_en   (glob_en),
  .cnt_en_q  (cnt_en_q),
  .ctr_wr    (ctr_wr),
  .cnt_q     (cnt_q),
  .stat_q    (stat_q),
  .mask_q    (mask_q),
  .irq       (irq),
  .bus_wdata (bus_wdata),
  .clr_wr    (clr_wr),
  .cfg_wr    (cfg_wr),
  .pm_hold   (pm_hold)
);

// File: tb/test_perf_counter_unit.sv
`timescale 1ns/1ps
module test_perf_counter_unit;
  localparam logic [31:0] VER = 32'h0003_0200;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic        beat_p0_wr = 0, beat_p0_rd = 0, beat_p1_wr = 0, beat_p1_rd = 0;
  logic        irq, pm_hold;

  int checks = 0, fails = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  perf_counter_unit #(.VERSION_ID(VER)) i_perf_counter_unit (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .beat_p0_wr(beat_p0_wr), .beat_p0_rd(beat_p0_rd),
    .beat_p1_wr(beat_p1_wr), .beat_p1_rd(beat_p1_rd),
    .irq(irq), .pm_hold(pm_hold)
  );

  function automatic logic [15:0] cnt_addr(input int n);
    return 16'(16'h1D00 + 8 * n);
  endfunction

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // All tasks start and end on a falling edge
  task automatic wr(input logic [15:0] a, input logic [63:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [63:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [63:0] v;
    rd(16'h1C00, v); chk("R1 run", v, 0);
    rd(16'h1C70, v); chk("R1 mask", v, 64'hFF);
    rd(16'h1C78, v); chk("R1 status", v, 0);
    rd(cnt_addr(3), v); chk("R1 counter3", v, 0);
    chk("R1 irq", {63'd0, irq}, 0);
    chk("R1 pm_hold", {63'd0, pm_hold}, 0);
  endtask

  logic [63:0] c0_exp;

  task automatic t_count;
    logic [63:0] v;
    int n_p1w = 0, n_p1r = 0, n_p0w = 0, n_p0r = 0;
    localparam int K = 20;
    localparam logic [63:0] PRE3 = 64'h0123_4567_89AB_CDEF;
    wr(16'h1C80, 64'hE2E1_6261);          // c0..c3: p1wr, p1rd, p0wr, p0rd
    wr(16'h1C84, 64'hE100_5500);          // c4 cycles, c5 unassigned, c6 cycles, c7 p0wr
    wr(16'h1C04, 64'hBF);                 // c6 disabled
    wr(cnt_addr(3), PRE3);
    rd(16'h1C80, v); chk("R3 select readback", v, 64'hE2E1_6261);
    wr(16'h1C00, 1);
    for (int i = 0; i < K; i++) begin
      beat_p1_wr = (i % 2 == 0); beat_p1_rd = (i % 3 == 0);
      beat_p0_wr = (i % 5 == 0); beat_p0_rd = (i < 7);
      n_p1w += int'(beat_p1_wr); n_p1r += int'(beat_p1_rd);
      n_p0w += int'(beat_p0_wr); n_p0r += int'(beat_p0_rd);
      @(negedge clk);
    end
    {beat_p0_wr, beat_p0_rd, beat_p1_wr, beat_p1_rd} = '0;
    wr(16'h1C00, 0);
    rd(cnt_addr(0), v); chk("R3 code 0x61", v, 64'(n_p1w)); c0_exp = v;
    rd(cnt_addr(1), v); chk("R3 code 0x62", v, 64'(n_p1r));
    rd(cnt_addr(2), v); chk("R3 code 0xE1", v, 64'(n_p0w));
    rd(cnt_addr(3), v); chk("R2 preload plus count", v, PRE3 + 64'(n_p0r));
    rd(cnt_addr(4), v); chk("R4 cycle count", v, 64'(K + 1));
    rd(cnt_addr(5), v); chk("R3 unassigned code", v, 0);
    rd(cnt_addr(6), v); chk("R4 own enable clear", v, 0);
    rd(cnt_addr(7), v); chk("R3 shared event", v, 64'(n_p0w));
    c0_exp = 64'(n_p1w);
  endtask

  task automatic t_disabled;
    logic [63:0] v;
    {beat_p0_wr, beat_p0_rd, beat_p1_wr, beat_p1_rd} = '1;
    repeat (5) @(negedge clk);
    {beat_p0_wr, beat_p0_rd, beat_p1_wr, beat_p1_rd} = '0;
    rd(cnt_addr(0), v); chk("R4 global enable clear", v, c0_exp);
  endtask

  task automatic t_overflow;
    logic [63:0] v;
    wr(16'h1C84, 0);                      // c7 counts cycles
    wr(16'h1C04, 64'h80);
    wr(cnt_addr(7), 64'hFFFF_FFFF_FFFF_FFFE);
    wr(16'h1C70, 64'h7F);
    wr(16'h1C00, 1);                      // edge A
    chk("R6 irq before wrap", {63'd0, irq}, 0);
    @(negedge clk);                       // A+1: all ones
    chk("R5 no flag at all ones", {63'd0, irq}, 0);
    @(negedge clk);                       // A+2: wraps
    chk("R5 wrap raises irq", {63'd0, irq}, 1);
    wr(16'h1C00, 0);                      // A+3 still counts
    rd(cnt_addr(7), v); chk("R5 counter after wrap", v, 1);
    rd(16'h1C78, v); chk("R5 status bit", v, 64'h80);
    wr(16'h1C78, 0);
    rd(16'h1C78, v); chk("R5 status write ignored", v, 64'h80);
    wr(16'h1C70, 64'hFF);
    chk("R6 masked", {63'd0, irq}, 0);
    wr(16'h1C70, 64'h7F);
    chk("R6 unmasked", {63'd0, irq}, 1);
    wr(16'h1C7C, 64'h7F);
    rd(16'h1C78, v); chk("R7 zero bits keep status", v, 64'h80);
    wr(16'h1C7C, 64'h80);
    rd(16'h1C78, v); chk("R7 one bit clears", v, 0);
    chk("R7 irq after clear", {63'd0, irq}, 0);
  endtask

  task automatic t_priority;
    logic [63:0] v;
    wr(16'h1C00, 1);
    wr(cnt_addr(7), 64'd100);             // counting, write wins
    wr(16'h1C00, 0);                      // one more increment
    rd(cnt_addr(7), v); chk("R8 write over increment", v, 64'd101);
  endtask

  task automatic t_misc;
    logic [63:0] v;
    wr(16'h0534, 64'hFFFF_FFFF);
    chk("R9 pm_hold set", {63'd0, pm_hold}, 1);
    rd(16'h0534, v); chk("R9 cfg readback", v, 64'h200);
    wr(16'h0534, 0);
    chk("R9 pm_hold clear", {63'd0, pm_hold}, 0);
    rd(16'h1CF0, v); chk("R10 version", v, 64'(VER));
    wr(16'h1CF0, 0);
    rd(16'h1CF0, v); chk("R10 version write ignored", v, 64'(VER));
    rd(16'h1C08, v); chk("R11 unmapped reads zero", v, 0);
    @(negedge clk);
    chk("R11 read data held", bus_rdata, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_count();
    t_disabled();
    t_overflow();
    t_priority();
    t_misc();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule